// File: doc/BRIEF.md
# Paged Write Buffer and Commit Sequencer

This block sits between a serial-bus slave front end and a 256-byte, 8-bit storage array. While a write transaction is open, each data byte is placed in a 16-entry page buffer at the offset given by the low bits of a byte pointer. The offset then advances and wraps inside the current page. The high pointer bits select the page and never change as bytes arrive. A per-entry valid bit records which offsets have been loaded.

Nothing reaches the array until the transaction closes with a stop strobe. If the stop comes with at least one loaded entry and the protection logic is not rejecting the write, a commit cycle starts. The sequencer walks the 16 offsets one clock at a time and writes only the loaded entries into the selected page. It holds `busy` high for a fixed number of clocks, set by a parameter. A start strobe, a rejected stop and a stop with nothing loaded all empty the buffer.

The array comes out of reset erased, with every byte at FFh. A combinational read port lets the surrounding logic fetch any byte.

Top module: `page_commit_seq`

## Requirements
- R1: After reset, `busy` is 0, `ptrOut` is 00h and every array byte read through `rdAddr`/`rdData` is FFh.
- R2: An `addrLoad` pulse while idle copies `addrIn` into `ptrOut` on the next clock.
- R3: Each `dataStb` pulse while idle stores `dataIn` at offset `ptrOut[3:0]`. It then increments `ptrOut[3:0]` modulo 16 and leaves `ptrOut[7:4]` unchanged.
- R4: When more than 16 bytes arrive, a later byte replaces the earlier byte held at the same offset. The commit writes at most 16 bytes.
- R5: A commit writes only the offsets that were loaded, each to address {`ptrOut[7:4]`, offset}. All other array bytes keep their values.
- R6: The array does not change before the stop strobe. `busy` rises on the first clock after a stop with loaded data and `rejectIn` low.
- R7: Once raised, `busy` stays high for exactly `WR_CYCLES` clocks.
- R8: A stop with `rejectIn` high, or with no byte loaded, leaves `busy` low and writes nothing. It also empties the buffer, so a later bare stop commits nothing.
- R9: A `startStb` pulse empties the buffer, and bytes loaded before it are never committed.
- R10: While `busy` is high, `startStb`, `addrLoad`, `dataStb` and `stopStb` are ignored: the pointer, the buffer and the array keep their state. The buffer is empty when `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | One-clock pulse marking a bus START |
| addrLoad | input | 1 | One-clock pulse: byte address on `addrIn` is valid |
| addrIn | input | ADDR_W | Byte address |
| dataStb | input | 1 | One-clock pulse: data byte on `dataIn` is valid |
| dataIn | input | DATA_W | Data byte |
| stopStb | input | 1 | One-clock pulse marking a bus STOP |
| rejectIn | input | 1 | Write refused by protection logic, sampled with `stopStb` |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Array byte at `rdAddr` (combinational) |
| busy | output | 1 | Commit cycle in progress |
| ptrOut | output | ADDR_W | Current byte pointer |
| memWe | output | 1 | Array write enable for this clock |
| memAddr | output | ADDR_W | Array write address |
| memWdata | output | DATA_W | Array write data |

## Verification
Strobes are driven on the falling edge and sampled on the next rising edge, so a pointer update and the rise of `busy` are both due one clock after the strobe. The bench reads them at the falling edge that follows the sampling edge. The commit length is measured by counting the falling edges at which `busy` is high, and the count must equal `WR_CYCLES`. Array contents are compared only after `busy` has dropped, because the last possible write lands on the 16th clock of the cycle. The array is also compared once before each stop to show that nothing was written early.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // offset bits inside one page; page holds 2**PAGE_BITS bytes
  localparam int PAGE_BITS = 4;
  localparam int PAGE_LEN  = 1 << PAGE_BITS;

  typedef enum logic {ST_IDLE, ST_COMMIT} pcsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                 clrMask;
    logic                 capture;
    logic                 ptrLoad;
    logic                 slotEn;
    logic [PAGE_BITS-1:0] slot;
  } pcsCtl_t;
endpackage

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcsCtl_t           ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              anyValid,
  output logic [ADDR_W-1:0] ptrOut,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0]    ptr;
  logic [PAGE_LEN-1:0]  validMask;
  logic [DATA_W-1:0]    slotData [PAGE_LEN];
  logic [DATA_W-1:0]    cells    [DEPTH];
  logic [PAGE_BITS-1:0] curOff;
  logic [PG_W-1:0]      curPage;

  assign curOff  = ptr[PAGE_BITS-1:0];
  assign curPage = ptr[ADDR_W-1:PAGE_BITS];

  // byte pointer: page bits only change on an address load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctl.ptrLoad) begin
      ptr <= addrIn;
    end else if (ctl.capture) begin
      ptr <= {curPage, curOff + 1'b1};
    end
  end

  // one buffer slot per in-page offset
  for (genvar g = 0; g < PAGE_LEN; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validMask[g] <= 1'b0;
        slotData[g]  <= '0;
      end else if (ctl.clrMask) begin
        validMask[g] <= 1'b0;
      end else if (ctl.capture && (curOff == PAGE_BITS'(g))) begin
        validMask[g] <= 1'b1;
        slotData[g]  <= dataIn;
      end
    end
  end

  assign anyValid = |validMask;
  assign memWe    = ctl.slotEn && validMask[ctl.slot];
  assign memAddr  = {curPage, ctl.slot};
  assign memWdata = slotData[ctl.slot];

  // storage array, erased (all ones) by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (memWe) begin
      cells[memAddr] <= memWdata;
    end
  end

  assign rdData = cells[rdAddr];
  assign ptrOut = ptr;
endmodule

// File: rtl/pcs_control.sv
module pcs_control
  import pcs_pkg::*;
#(
  parameter int WR_CYCLES = 250000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startStb,
  input  logic    addrLoad,
  input  logic    dataStb,
  input  logic    stopStb,
  input  logic    rejectIn,
  input  logic    anyValid,
  output pcsCtl_t ctl,
  output logic    busy
);
  localparam int CNT_W = $clog2(WR_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  pcsState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             goCommit;
  logic             lastTick;

  assign busy     = (state == ST_COMMIT);
  assign goCommit = !busy && stopStb && anyValid && !rejectIn;
  assign lastTick = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (goCommit) state <= ST_COMMIT;
        end
        ST_COMMIT: begin
          if (lastTick) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.clrMask = lastTick ||
                  (!busy && (startStb || (stopStb && !goCommit)));
    ctl.ptrLoad = !busy && !startStb && addrLoad;
    ctl.capture = !busy && !startStb && !addrLoad && dataStb;
    ctl.slotEn  = busy && ({1'b0, cnt} < (CNT_W + 1)'(PAGE_LEN));
    ctl.slot    = cnt[PAGE_BITS-1:0];
  end
endmodule

// File: rtl/page_commit_seq.sv
module page_commit_seq
  import pcs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataStb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              stopStb,
  input  logic              rejectIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic [ADDR_W-1:0] ptrOut,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  pcsCtl_t ctl;
  logic    anyValid;

  pcs_control #(.WR_CYCLES(WR_CYCLES)) uCtl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .addrLoad(addrLoad),
    .dataStb(dataStb), .stopStb(stopStb), .rejectIn(rejectIn),
    .anyValid(anyValid), .ctl(ctl), .busy(busy)
  );

  pcs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrIn(addrIn), .dataIn(dataIn),
    .rdAddr(rdAddr), .anyValid(anyValid), .ptrOut(ptrOut), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .rdData(rdData)
  );
endmodule

// File: rtl/page_commit_seq_chk.sv
module page_commit_seq_chk #(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 250000
) (
  input logic              clk,
  input logic              rstN,
  input logic              startStb,
  input logic              addrLoad,
  input logic              dataStb,
  input logic              stopStb,
  input logic              rejectIn,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] ptrOut
);
  logic [31:0] runLen;
  logic [31:0] wrCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen  <= '0;
      wrCount <= '0;
    end else begin
      runLen  <= busy ? runLen + 1 : '0;
      wrCount <= busy ? wrCount + (memWe ? 1 : 0) : '0;
    end
  end

  // R5: writes happen only inside a commit
  a_r5_write_in_commit: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R4: no more than one page of writes per commit
  a_r4_page_limit: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> wrCount <= 32'd16);

  // R6: a commit begins only from an accepted stop
  a_r6_start_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(stopStb) && !$past(rejectIn)));

  // R7: commit length
  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == WR_CYCLES);

  // R8: rejected stop starts nothing
  a_r8_reject_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && rejectIn && !busy) |=> !busy);

  // R10: pointer frozen during commit
  a_r10_ptr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(ptrOut));

  // R3: offset advances and wraps inside the page
  a_r3_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    (dataStb && !busy && !startStb && !addrLoad) |=>
      (ptrOut[ADDR_W-1:4] == $past(ptrOut[ADDR_W-1:4]) &&
       ptrOut[3:0] == $past(ptrOut[3:0]) + 4'd1));
endmodule

bind page_commit_seq page_commit_seq_chk #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .addrLoad(addrLoad),
  .dataStb(dataStb), .stopStb(stopStb), .rejectIn(rejectIn),
  .busy(busy), .memWe(memWe), .ptrOut(ptrOut)
);

// File: tb/sim_page_commit_seq.sv
`timescale 1ns/1ps
module sim_page_commit_seq;
  localparam int WRC = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0, addrLoad = 1'b0, dataStb = 1'b0;
  logic       stopStb = 1'b0, rejectIn = 1'b0;
  logic [7:0] addrIn = '0, dataIn = '0, rdAddr = '0;
  logic [7:0] rdData, ptrOut, memAddr, memWdata;
  logic       busy, memWe;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [256];

  always #10 clk = ~clk;

  page_commit_seq #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .addrLoad(addrLoad),
    .addrIn(addrIn), .dataStb(dataStb), .dataIn(dataIn), .stopStb(stopStb),
    .rejectIn(rejectIn), .rdAddr(rdAddr), .rdData(rdData), .busy(busy),
    .ptrOut(ptrOut), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  // {addr, count, seed, reject}
  localparam logic [21:0] VEC [8] = '{
    {8'h00, 5'd1,  8'h11, 1'b0},
    {8'h35, 5'd4,  8'h20, 1'b0},
    {8'h7C, 5'd6,  8'h40, 1'b0},
    {8'hA0, 5'd16, 8'h60, 1'b0},
    {8'hC3, 5'd18, 8'h80, 1'b0},
    {8'hE0, 5'd3,  8'h99, 1'b1},
    {8'hF0, 5'd0,  8'h00, 1'b0},
    {8'hFF, 5'd2,  8'hD0, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startStb = 1'b1;
    @(negedge clk) startStb = 1'b0;
  endtask

  task automatic pulseAddr(input logic [7:0] a);
    @(negedge clk) begin addrLoad = 1'b1; addrIn = a; end
    @(negedge clk) addrLoad = 1'b0;
  endtask

  task automatic pulseData(input logic [7:0] d);
    @(negedge clk) begin dataStb = 1'b1; dataIn = d; end
    @(negedge clk) dataStb = 1'b0;
  endtask

  task automatic pulseStop(input logic rej);
    @(negedge clk) begin stopStb = 1'b1; rejectIn = rej; end
    @(negedge clk) begin stopStb = 1'b0; rejectIn = 1'b0; end
  endtask

  // counts falling edges with busy high; called right after pulseStop
  task automatic busyRun(output int n);
    n = 0;
    while (busy && n < 10 * WRC) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic compareArray(string req);
    int bad = 0;
    int firstA = -1;
    logic [7:0] firstV = '0;
    for (int a = 0; a < 256; a++) begin
      rdAddr = 8'(a);
      #0.1;
      if (rdData !== model[a]) begin
        bad++;
        if (firstA < 0) begin firstA = a; firstV = rdData; end
      end
    end
    if (bad != 0)
      $display("FAIL %s array byte %0h actual=%0h expected=%0h (%0d bad)",
               req, firstA, firstV, model[firstA], bad);
    checks++;
    if (bad != 0) failures++;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int n;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 ptr", ptrOut, 8'h00);
    compareArray("R1");

    // vector table: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 8; v++) begin
      logic [7:0] a, seed;
      int cnt;
      logic rej, doCommit;
      a = VEC[v][21:14]; cnt = int'(VEC[v][13:9]);
      seed = VEC[v][8:1]; rej = VEC[v][0];
      doCommit = (cnt > 0) && !rej;
      pulseStart();
      pulseAddr(a);
      check("R2 ptr load", ptrOut, a);
      for (int k = 0; k < cnt; k++) pulseData(seed + 8'(k));
      check("R3 ptr step/wrap", ptrOut, {a[7:4], a[3:0] + 4'(cnt)});
      compareArray("R6 no write before stop");
      pulseStop(rej);
      check(doCommit ? "R6 busy after stop" : "R8 no commit", busy, doCommit);
      busyRun(n);
      check("R7 busy length", n, doCommit ? WRC : 0);
      if (doCommit)
        for (int k = 0; k < cnt; k++)
          model[{a[7:4], a[3:0] + 4'(k)}] = seed + 8'(k);
      compareArray(cnt > 16 ? "R4 overwrite" : "R5 commit content");
    end

    // R9: start empties the buffer
    pulseStart();
    pulseAddr(8'h40);
    pulseData(8'h01); pulseData(8'h02); pulseData(8'h03);
    pulseStart();
    pulseStop(1'b0);
    check("R9 no commit after start", busy, 0);
    compareArray("R9 array");

    // R10: strobes ignored while busy
    pulseStart();
    pulseAddr(8'h50);
    pulseData(8'h5A); pulseData(8'h5B);
    pulseStop(1'b0);
    check("R10 busy", busy, 1);
    pulseAddr(8'h90);
    pulseData(8'hEE);
    pulseStop(1'b0);
    pulseStart();
    busyRun(n);
    check("R10 busy length", n, WRC - 8);
    check("R10 ptr kept", ptrOut, 8'h52);
    model[8'h50] = 8'h5A; model[8'h51] = 8'h5B;
    compareArray("R10 array");
    pulseStop(1'b0);
    check("R10 buffer empty after commit", busy, 0);

    // R8: rejected stop clears the buffer
    pulseStart();
    pulseAddr(8'h60);
    pulseData(8'h77);
    pulseStop(1'b1);
    check("R8 reject idle", busy, 0);
    pulseStop(1'b0);
    check("R8 cleared buffer", busy, 0);
    compareArray("R8 array");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule